// File: doc/BRIEF.md
# Programmable interval timer channel

One down-counting channel of a PC-style interval timer. The channel counts clock cycles against a 16-bit programmed count and drives one output line whose waveform depends on the operating mode. Six modes are available: a single rise at terminal count, a gate-started one-shot, a rate generator, a square wave, and software- and gate-triggered one-clock strobes. The gate input can restart counting on a rising edge.

A host programs the channel over a byte-wide write port. A control byte selects the mode and the count access order, or issues a latch command. Count bytes follow in that order. The current count can be read back live, or frozen by a latch command and then read back in the same byte order. Every clock cycle is one count tick. The BCD flag is accepted, but counting is always binary. The gate edge detector takes its reset value from a parameter, so an instance whose gate idles low can be set up for that.

Top module: `pit_channel`

## Requirements
- R1: A count of zero is loaded as 65536. In mode 0 the output stays low for at least 65535 clocks after such a load. A value captured k clocks after the load reads back as (65536-k) mod 65536.
- R2: A control byte has four fields. Bit 0 is the BCD flag and has no effect on counting. Bits 3:1 are the mode; the values 6 and 7 act as modes 2 and 3. Bits 5:4 are the access field: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits 7:6 are ignored. A control byte with a non-zero access field halts counting until a count is loaded. Until then the output is low in mode 0 and high in every other mode.
- R3: A count takes effect on the write of its last byte, and counting restarts from zero elapsed clocks. With low-only access the high byte is zero. With high-only access the low byte is zero.
- R4: Mode 0: k clocks after a load, the output is high when k >= count and low otherwise.
- R5: Mode 1: after a load the output stays high until a gate rising edge. k clocks after that edge, the output is high when k >= count.
- R6: Mode 2: k clocks after a load or retrigger, the output is low when k mod count = count-1 and high otherwise.
- R7: Mode 3: k clocks after a load or retrigger, the output is high when k mod count < (count+1)/2, rounded down, and low otherwise.
- R8: Mode 4 counts from the load. Mode 5 stays high until a gate rising edge and counts from that edge. In both modes the output is low only at k = count.
- R9: In modes 1, 2, 3 and 5, a rising edge on the gate restarts counting from zero elapsed clocks. In modes 0 and 4 gate edges have no effect, and the gate level has no effect in any mode.
- R10: Without a latch, a read returns the current value: the count minus the elapsed clocks. In modes 2 and 3 the elapsed clocks are counted within the period. A latch command freezes that value. Reads then return it in the access order (low-only and high-only return one byte each time, low-then-high alternates). The latch is released after the last byte of that order. A latch command while a value is held is ignored.
- R11: After reset the channel is in mode 3 with count 65536 and low-then-high access. The output is high for 32768 clocks and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Gate; rising edge retriggers in modes 1, 2, 3, 5 |
| wr_en | input | 1 | Host write strobe |
| wr_ctl | input | 1 | 1 selects the control byte, 0 a count byte |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe; advances the read byte order |
| rd_data | output | 8 | Read byte (live or latched value) |
| out | output | 1 | Channel output waveform |

## Verification
The assertions assume that a host write and a host read never occur in the same cycle. They also assume that a latch command is never issued in the same cycle as a read, and that the gate never changes in the cycle that loads a count. The bench drives every write, read and gate change as a separate one-cycle task, in sequence. Random trials draw modes 0, 2, 3 and 4 with counts of 1 to 40, and each trial runs long enough to span two periods. The gate is kept steady during these trials, so the restart behaviour is exercised only in the directed cases.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W = 16;
  localparam int EXT_W = CNT_W + 1;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  // zero means a full 2^CNT_W period
  function automatic logic [EXT_W-1:0] fix_count(input logic [CNT_W-1:0] v);
    logic [EXT_W-1:0] r;
    if (v == '0) r = {1'b1, {CNT_W{1'b0}}};
    else r = {1'b0, v};
    return r;
  endfunction

  // modes 6 and 7 fold onto 2 and 3
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    logic [2:0] r;
    if (m[2] && m[1]) r = {1'b0, m[1:0]};
    else r = m;
    return r;
  endfunction

  function automatic logic retrig_mode(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd5);
  endfunction

  function automatic logic gate_start_mode(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd5);
  endfunction

  function automatic logic wave(input logic [2:0] m, input logic waiting,
                                input logic started, input logic [EXT_W-1:0] d,
                                input logic [EXT_W-1:0] p, input logic [EXT_W-1:0] cnt);
    logic o;
    if (waiting) o = (m != 3'd0);
    else if (!started) o = 1'b1;
    else begin
      case (m)
        3'd0, 3'd1: o = (d >= cnt);
        3'd2:       o = (p != cnt - 1'b1);
        3'd3:       o = (p < ((cnt + 1'b1) >> 1));
        default:    o = (d != cnt);
      endcase
    end
    return o;
  endfunction

  function automatic logic [CNT_W-1:0] live_value(input logic [2:0] m,
                                                  input logic [EXT_W-1:0] d,
                                                  input logic [EXT_W-1:0] p,
                                                  input logic [EXT_W-1:0] cnt);
    logic [EXT_W-1:0] e;
    logic [EXT_W-1:0] v;
    if (m == 3'd2 || m == 3'd3) e = p;
    else if (d > cnt) e = cnt;
    else e = d;
    v = cnt - e;
    return v[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/pit_host.sv
module pit_host
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [2:0]        mode_q,
  output acc_e              acc_q,
  output logic [EXT_W-1:0]  count_q,
  output logic              cw_wr,
  output logic              latch_cmd,
  output logic              load_p,
  output logic [CNT_W-1:0]  load_raw
);
  logic              wphase;
  logic [BYTE_W-1:0] lsb_q;
  logic              is_ctl;
  logic              is_cnt;

  assign is_ctl    = wr_en && wr_ctl;
  assign is_cnt    = wr_en && !wr_ctl;
  assign cw_wr     = is_ctl && (wr_data[5:4] != 2'b00);
  assign latch_cmd = is_ctl && (wr_data[5:4] == 2'b00);

  always_comb begin
    load_p   = 1'b0;
    load_raw = '0;
    case (acc_q)
      ACC_LO: begin
        load_p   = is_cnt;
        load_raw = {{(CNT_W-BYTE_W){1'b0}}, wr_data};
      end
      ACC_HI: begin
        load_p   = is_cnt;
        load_raw = {wr_data, {(CNT_W-BYTE_W){1'b0}}};
      end
      ACC_BOTH: begin
        load_p   = is_cnt && wphase;
        load_raw = {wr_data, lsb_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 3'd3;
      acc_q   <= ACC_BOTH;
      count_q <= fix_count('0);
      wphase  <= 1'b0;
      lsb_q   <= '0;
    end else if (cw_wr) begin
      mode_q <= norm_mode(wr_data[3:1]);
      acc_q  <= acc_e'(wr_data[5:4]);
      wphase <= 1'b0;
    end else if (is_cnt) begin
      if (load_p) count_q <= fix_count(load_raw);
      if (acc_q == ACC_BOTH) begin
        if (!wphase) lsb_q <= wr_data;
        wphase <= !wphase;
      end
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter bit GATE_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [2:0]       mode_q,
  input  logic [EXT_W-1:0] count_q,
  input  logic             cw_wr,
  input  logic             load_p,
  output logic [EXT_W-1:0] d_q,
  output logic [EXT_W-1:0] p_q,
  output logic             started_q,
  output logic             waiting_q,
  output logic             retrig
);
  logic gate_q;
  logic gate_rise;

  assign gate_rise = gate && !gate_q;
  assign retrig    = gate_rise && retrig_mode(mode_q) && !waiting_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q    <= GATE_RESET;
      d_q       <= '0;
      p_q       <= '0;
      started_q <= 1'b1;
      waiting_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cw_wr) begin
        waiting_q <= 1'b1;
        started_q <= 1'b0;
        d_q       <= '0;
        p_q       <= '0;
      end else if (load_p) begin
        waiting_q <= 1'b0;
        started_q <= !gate_start_mode(mode_q);
        d_q       <= '0;
        p_q       <= '0;
      end else if (retrig) begin
        started_q <= 1'b1;
        d_q       <= '0;
        p_q       <= '0;
      end else if (started_q && !waiting_q) begin
        if (d_q <= count_q) d_q <= d_q + 1'b1;
        if (p_q == count_q - 1'b1) p_q <= '0;
        else p_q <= p_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_readback.sv
module pit_readback
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  acc_e              acc_q,
  input  logic              latch_cmd,
  input  logic              cw_wr,
  input  logic [CNT_W-1:0]  live,
  output logic [BYTE_W-1:0] rd_data,
  output logic              latched_q,
  output logic [CNT_W-1:0]  latch_q
);
  logic             rphase;
  logic             release_now;
  logic             hi_sel;
  logic [CNT_W-1:0] src;

  assign release_now = rd_en && ((acc_q != ACC_BOTH) || rphase);
  assign src         = latched_q ? latch_q : live;
  assign hi_sel      = (acc_q == ACC_HI) || ((acc_q == ACC_BOTH) && rphase);
  assign rd_data     = hi_sel ? src[CNT_W-1:CNT_W-BYTE_W] : src[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      latch_q   <= '0;
      rphase    <= 1'b0;
    end else if (cw_wr) begin
      latched_q <= 1'b0;
      rphase    <= 1'b0;
    end else begin
      if (rd_en && acc_q == ACC_BOTH) rphase <= !rphase;
      if (release_now) latched_q <= 1'b0;
      if (latch_cmd && !latched_q) begin
        latched_q <= 1'b1;
        latch_q   <= live;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter bit GATE_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              wr_en,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              out
);
  logic [2:0]       mode_q;
  acc_e             acc_q;
  logic [EXT_W-1:0] count_q;
  logic             cw_wr;
  logic             latch_cmd;
  logic             load_p;
  logic [CNT_W-1:0] load_raw;
  logic [EXT_W-1:0] d_q;
  logic [EXT_W-1:0] p_q;
  logic             started_q;
  logic             waiting_q;
  logic             retrig;
  logic [CNT_W-1:0] live;
  logic             latched_q;
  logic [CNT_W-1:0] latch_q;

  pit_host u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .mode_q(mode_q), .acc_q(acc_q), .count_q(count_q), .cw_wr(cw_wr),
    .latch_cmd(latch_cmd), .load_p(load_p), .load_raw(load_raw)
  );

  pit_counter #(.GATE_RESET(GATE_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_n), .gate(gate), .mode_q(mode_q), .count_q(count_q),
    .cw_wr(cw_wr), .load_p(load_p), .d_q(d_q), .p_q(p_q),
    .started_q(started_q), .waiting_q(waiting_q), .retrig(retrig)
  );

  assign live = live_value(mode_q, d_q, p_q, count_q);
  assign out  = wave(mode_q, waiting_q, started_q, d_q, p_q, count_q);

  pit_readback u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .acc_q(acc_q), .latch_cmd(latch_cmd),
    .cw_wr(cw_wr), .live(live), .rd_data(rd_data), .latched_q(latched_q),
    .latch_q(latch_q)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             out,
  input logic             rd_en,
  input logic [2:0]       mode_q,
  input logic             cw_wr,
  input logic             load_p,
  input logic [CNT_W-1:0] load_raw,
  input logic [EXT_W-1:0] count_q,
  input logic             retrig,
  input logic [EXT_W-1:0] d_q,
  input logic [EXT_W-1:0] p_q,
  input logic             latched_q,
  input logic [CNT_W-1:0] latch_q
);
  // R1
  a_r1_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p && load_raw == '0) |=> (count_q == {1'b1, {CNT_W{1'b0}}}));

  // R4
  a_r4_mode0_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out && !cw_wr && !load_p) |=> out);

  // R6
  a_r6_rate_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && !out && count_q != 1 && !cw_wr && !load_p) |=> out);

  // R8
  a_r8_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !out && !cw_wr) |=> out);

  // R9
  a_r9_retrig_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig && !cw_wr && !load_p) |=> (d_q == '0 && p_q == '0));

  // R10
  a_r10_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !rd_en && !cw_wr) |=> (latched_q && $stable(latch_q)));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out(out), .rd_en(rd_en), .mode_q(mode_q),
  .cw_wr(cw_wr), .load_p(load_p), .load_raw(load_raw), .count_q(count_q),
  .retrig(retrig), .d_q(d_q), .p_q(p_q), .latched_q(latched_q), .latch_q(latch_q)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_ctl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       out;

  int n_tests = 0;
  int n_fail = 0;
  int k = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst_n(rst_n), .gate(gate), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .out(out)
  );

  function automatic bit exp_out(int m, int c, int kk);
    case (m)
      0, 1: return kk >= c;
      2: return (kk % c) != (c - 1);
      3: return (kk % c) < ((c + 1) / 2);
      default: return kk != c;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic tick();
    @(negedge clk);
    k++;
  endtask

  task automatic step(string tag, int m, int c);
    check(tag, out, exp_out(m, c, k));
    tick();
  endtask

  task automatic wr(bit ctl, logic [7:0] b);
    wr_en = 1'b1; wr_ctl = ctl; wr_data = b;
    tick();
    wr_en = 1'b0; wr_ctl = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = rd_data;
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic gate_retrig();
    gate = 1'b0;
    tick();
    gate = 1'b1;
    tick();
    k = 0;
  endtask

  function automatic logic [7:0] ctl(int acc, int m, int bcd);
    return {2'b00, acc[1:0], m[2:0], bcd[0]};
  endfunction

  task automatic prog_both(int m, int c);
    wr(1'b1, ctl(3, m, 0));
    wr(1'b0, c[7:0]);
    wr(1'b0, c[15:8]);
    k = 0;
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1;
    int kl, mm, cc, sel;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    k = 0;

    // R11 reset state: mode 3, count 65536
    check("R11 out after reset", out, 1);
    while (k < 32767) tick();
    check("R11 high phase end", out, 1);
    tick();
    check("R11 low phase start", out, 0);
    wr(1'b1, 8'h00);
    rd(b0); rd(b1);
    check("R11 latched count", {b1, b0}, 16'h8000);

    // R2 control byte halts and sets initial output
    wr(1'b1, ctl(3, 0, 0));
    check("R2 mode0 waiting low", out, 0);
    tick();
    check("R2 mode0 waiting low later", out, 0);
    wr(1'b0, 8'd9);
    tick();
    check("R3 no load after one byte", out, 0);
    wr(1'b0, 8'd0);
    k = 0;
    for (int i = 0; i < 14; i++) step("R4 mode0 count 9", 0, 9);
    wr(1'b1, ctl(3, 4, 0));
    check("R2 mode4 waiting high", out, 1);

    // R1 zero count in mode 0
    prog_both(0, 0);
    while (k < 5) step("R1 zero count low", 0, 65536);
    kl = k;
    wr(1'b1, 8'h00);
    rd(b0); rd(b1);
    check("R1 latched zero count", {b1, b0}, (65536 - kl) & 16'hFFFF);
    while (k < 1000) tick();
    check("R1 still low", out, 0);

    // R2 mode field 6 folds to 2, BCD flag ignored; bits 7:6 ignored
    wr(1'b1, 8'hC0 | ctl(3, 6, 1));
    wr(1'b0, 8'd5); wr(1'b0, 8'd0);
    k = 0;
    for (int i = 0; i < 12; i++) step("R2 mode6 as rate gen", 2, 5);

    // R7 odd and even square waves
    prog_both(3, 7);
    for (int i = 0; i < 16; i++) step("R7 square odd", 3, 7);
    prog_both(3, 6);
    for (int i = 0; i < 14; i++) step("R7 square even", 3, 6);

    // R9 retrigger in mode 2 and mode 3
    prog_both(2, 6);
    for (int i = 0; i < 3; i++) step("R6 rate before retrig", 2, 6);
    gate_retrig();
    for (int i = 0; i < 13; i++) step("R9 rate after retrig", 2, 6);
    prog_both(3, 8);
    for (int i = 0; i < 6; i++) step("R7 square before retrig", 3, 8);
    gate_retrig();
    for (int i = 0; i < 10; i++) step("R9 square after retrig", 3, 8);

    // R9 gate edges ignored in modes 0 and 4
    prog_both(0, 12);
    for (int i = 0; i < 3; i++) step("R4 mode0 gate", 0, 12);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    for (int i = 0; i < 12; i++) step("R9 mode0 gate ignored", 0, 12);
    prog_both(4, 7);
    for (int i = 0; i < 2; i++) step("R8 mode4", 4, 7);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    for (int i = 0; i < 8; i++) step("R9 mode4 gate ignored", 4, 7);

    // R5 hardware one-shot
    prog_both(1, 5);
    for (int i = 0; i < 6; i++) begin check("R5 untriggered high", out, 1); tick(); end
    gate_retrig();
    for (int i = 0; i < 3; i++) step("R5 one-shot", 1, 5);
    gate_retrig();
    for (int i = 0; i < 9; i++) step("R5 one-shot retriggered", 1, 5);

    // R8 hardware strobe
    prog_both(5, 4);
    for (int i = 0; i < 6; i++) begin check("R8 mode5 untriggered", out, 1); tick(); end
    gate_retrig();
    for (int i = 0; i < 10; i++) step("R8 mode5 strobe", 5, 4);

    // R10 latch, ignored second latch, release
    prog_both(2, 1000);
    while (k < 10) tick();
    kl = k;
    wr(1'b1, 8'h00);
    while (k < 16) tick();
    wr(1'b1, 8'h00);
    rd(b0); rd(b1);
    check("R10 latched value", {b1, b0}, 1000 - kl);
    kl = k;
    wr(1'b1, 8'h00);
    rd(b0); rd(b1);
    check("R10 latch released", {b1, b0}, 1000 - kl);

    // R3 low-only access, R10 single-byte reads and live read
    wr(1'b1, ctl(1, 2, 0));
    wr(1'b0, 8'h30);
    k = 0;
    while (k < 4) step("R3 low-only rate", 2, 48);
    kl = k;
    wr(1'b1, 8'h00);
    tick(); tick();
    rd(b0);
    check("R10 low-only latched", b0, 48 - kl);
    kl = k;
    rd(b0);
    check("R10 low-only live", b0, 48 - kl);

    // R3 high-only access: count 256
    wr(1'b1, ctl(2, 0, 0));
    wr(1'b0, 8'h01);
    k = 0;
    while (k < 3) tick();
    wr(1'b1, 8'h00);
    rd(b1);
    check("R10 high-only byte", b1, 8'h00);
    while (k < 255) tick();
    step("R3 high-only count", 0, 256);
    step("R3 high-only count", 0, 256);

    // random trials, gate held high
    for (int t = 0; t < 24; t++) begin
      sel = $urandom % 4;
      mm = (sel == 0) ? 0 : (sel == 1) ? 2 : (sel == 2) ? 3 : 4;
      cc = 1 + ($urandom % 40);
      if ($urandom % 2) begin
        wr(1'b1, ctl(1, mm, 0));
        wr(1'b0, cc[7:0]);
        k = 0;
      end else prog_both(mm, cc);
      for (int i = 0; i < 2 * cc + 6; i++)
        step(mm == 0 ? "R4 random" : mm == 2 ? "R6 random" : mm == 3 ? "R7 random" : "R8 random", mm, cc);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule